// File: doc/BRIEF.md
# Dual-Mode Host Register Bus Slave

This block lets an external processor reach a small bank of 16-bit control registers and a FIFO data port through an asynchronous strobe-based bus. The host qualifies every cycle with an active-low chip select, then pulses one read strobe or either of two byte-lane write strobes. All strobes are resynchronised into the local clock. A write takes effect once, when the strobe is released. Read data is driven for as long as the synchronised read strobe is held.

The address can arrive in two ways. In separate mode it comes from six word-address lines. In multiplexed mode there are no address lines: the host first places the address on the data bus and pulses an address-latch strobe, then uses the same lines for data. A strap pin, sampled once on the first clock after reset release, selects the mode.

Register 0 is the control register. Its bit 0 enables a byte swap on the FIFO port, applied on both push and pop. Registers 1 to N_REGS-1 are scratch storage that stands in for the real register content. Word address 0x08 is the FIFO port.

Top module: `cpu_bus_if`

## Requirements
- R1: The bus mode (strap 0 = separate, 1 = multiplexed) is taken on the first clock after reset release and does not follow later strap changes.
- R2: In separate mode the word address is `addr_i[5:0]`. Word addresses 0..3 select registers 0..3.
- R3: In multiplexed mode the word address is taken from `data_i[6:1]` when the latch strobe `ale_i` falls. That address is kept for every later access until the next latch pulse.
- R4: `wr_lo_ni` low writes bits 7:0 and `wr_hi_ni` low writes bits 15:8 of a register. A byte lane whose strobe stays high keeps its old value.
- R5: `data_oe_o` is high exactly while both chip select and read strobe, after two synchronising flops, are low. While `data_oe_o` is low, `data_o` is zero.
- R6: Each write access is committed exactly once, on the release of its write strobes.
- R7: A write to address 0x08 pushes one word into a 4-deep FIFO. A read of 0x08 shows the oldest word and pops it when the read strobe is released, so words come out in first-in first-out order.
- R8: When control bit 0 is 1, the two bytes of a word are exchanged on both FIFO push and FIFO pop. When it is 0, words pass through unchanged.
- R9: A read of an unmapped address (4..7, 9..63) returns zero. A write to one leaves every register and the FIFO unchanged.
- R10: A push to a full FIFO is dropped. A read of an empty FIFO returns zero and pops nothing.
- R11: After reset all registers read zero, the FIFO is empty and the data bus is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_strap_i | input | 1 | Bus mode strap, 1 = multiplexed |
| cs_ni | input | 1 | Active-low chip select |
| rd_ni | input | 1 | Active-low read strobe |
| wr_lo_ni | input | 1 | Active-low low-byte write strobe |
| wr_hi_ni | input | 1 | Active-low high-byte write strobe |
| ale_i | input | 1 | Address latch strobe, multiplexed mode |
| addr_i | input | 6 | Word address, separate mode |
| data_i | input | 16 | Data bus in (also address in multiplexed mode) |
| data_o | output | 16 | Data bus out |
| data_oe_o | output | 1 | Data bus output enable |

## Verification
A wrong mode latch or a lost address latch shows up on the first read after it. That read returns another register's value or zero, and a write is lost or lands in the wrong register, so the next read-back of that register exposes it. A FIFO pointer or count fault shows as a wrong word, a missing word or a duplicated word within the next few pops. A second commit of one write shows as an extra FIFO entry at the following empty read. Any fault in the strobe synchronisers moves `data_oe_o` off its two-clock delay, and this is compared on every cycle.

// File: rtl/cpu_bus_pkg.sv
package cpu_bus_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 16;

  typedef enum logic {BUS_SEPARATE = 1'b0, BUS_MUX = 1'b1} bus_mode_e;

  function automatic logic [DATA_W-1:0] byte_swap(input logic [DATA_W-1:0] d);
    return {d[7:0], d[15:8]};
  endfunction
endpackage

// File: rtl/cbi_sync.sv
module cbi_sync #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1, s2;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1[i] <= RST_VAL[i];
        s2[i] <= RST_VAL[i];
      end else begin
        s1[i] <= d_i[i];
        s2[i] <= s1[i];
      end
    end
  end

  assign q_o = s2;
endmodule

// File: rtl/cbi_regfile.sv
module cbi_regfile import cpu_bus_pkg::*; #(
  parameter int N_REGS = 4,
  localparam int IDX_W = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        be_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              swap_o
);
  logic [DATA_W-1:0] regs [N_REGS];

  for (genvar r = 0; r < N_REGS; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs[r] <= '0;
      else if (we_i && waddr_i == IDX_W'(r)) begin
        if (be_i[0]) regs[r][7:0]  <= wdata_i[7:0];
        if (be_i[1]) regs[r][15:8] <= wdata_i[15:8];
      end
    end
  end

  assign rdata_o = regs[raddr_i];
  assign swap_o  = regs[0][0];

  // R6: a commit always carries at least one lane
  a_r6_lane_present: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> be_i != 2'b00);
endmodule

// File: rtl/cbi_fifo.sv
module cbi_fifo import cpu_bus_pkg::*; #(
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic              full_o,
  output logic              empty_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wp, rp;
  logic [CW-1:0]     count;
  logic              push_ok, pop_ok;

  assign full_o  = (count == CW'(DEPTH));
  assign empty_o = (count == '0);
  assign push_ok = push_i & ~full_o;
  assign pop_ok  = pop_i & ~empty_o;
  assign head_o  = empty_o ? '0 : mem[rp];

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wp] <= din_i;
  end

  // DEPTH is a power of two, pointers wrap naturally
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= wp + 1'b1;
      if (pop_ok)  rp <= rp + 1'b1;
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  a_r10_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= CW'(DEPTH));
  a_r10_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> $stable(count));
  a_r10_empty_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> $stable(rp));
endmodule

// File: rtl/cpu_bus_if.sv
module cpu_bus_if import cpu_bus_pkg::*; #(
  parameter int               N_REGS     = 4,
  parameter int               FIFO_DEPTH = 4,
  parameter logic [ADDR_W-1:0] FIFO_ADDR = 6'h08,
  localparam int IDX_W = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_strap_i,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              wr_lo_ni,
  input  logic              wr_hi_ni,
  input  logic              ale_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  localparam logic [ADDR_W-1:0] REG_LIM = ADDR_W'(N_REGS);

  // strobe synchronisers: {ale, cs, rd, wr_hi, wr_lo}
  logic [4:0] strb_s;
  logic ale_s, cs_s, rd_s, whi_s, wlo_s;
  cbi_sync #(.W(5), .RST_VAL(5'b01111)) i_sync (
    .clk_i, .rst_ni,
    .d_i({ale_i, cs_ni, rd_ni, wr_hi_ni, wr_lo_ni}),
    .q_o(strb_s)
  );
  assign {ale_s, cs_s, rd_s, whi_s, wlo_s} = strb_s;

  // mode strap taken once after reset release
  bus_mode_e mode_q;
  logic      mode_done;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= BUS_SEPARATE;
      mode_done <= 1'b0;
    end else if (!mode_done) begin
      mode_q    <= bus_mode_e'(mode_strap_i);
      mode_done <= 1'b1;
    end
  end

  // multiplexed address latch
  logic              ale_q;
  logic              ale_fall;
  logic [ADDR_W-1:0] ale_addr;
  assign ale_fall = ale_q & ~ale_s;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ale_q    <= 1'b0;
      ale_addr <= '0;
    end else begin
      ale_q <= ale_s;
      if (ale_fall && mode_q == BUS_MUX) ale_addr <= data_i[ADDR_W:1];
    end
  end

  logic [ADDR_W-1:0] addr_sel;
  assign addr_sel = (mode_q == BUS_MUX) ? ale_addr : addr_i;

  // write capture and commit on strobe release
  logic              wr_act, wr_act_q, commit;
  logic [1:0]        be_q;
  logic [DATA_W-1:0] wdata_q;
  logic [ADDR_W-1:0] waddr_q;
  assign wr_act = ~cs_s & (~wlo_s | ~whi_s);
  assign commit = wr_act_q & ~wr_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_act_q <= 1'b0;
      be_q     <= '0;
      wdata_q  <= '0;
      waddr_q  <= '0;
    end else begin
      wr_act_q <= wr_act;
      if (commit) be_q <= '0;
      else if (wr_act) begin
        be_q    <= be_q | {~whi_s, ~wlo_s};
        wdata_q <= data_i;
        waddr_q <= addr_sel;
      end
    end
  end

  // read path, pop on strobe release
  logic              rd_act, rd_act_q, rd_end;
  logic [ADDR_W-1:0] raddr_q;
  assign rd_act = ~cs_s & ~rd_s;
  assign rd_end = rd_act_q & ~rd_act;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_act_q <= 1'b0;
      raddr_q  <= '0;
    end else begin
      rd_act_q <= rd_act;
      if (rd_act) raddr_q <= addr_sel;
    end
  end

  logic              swap_en;
  logic [DATA_W-1:0] reg_rdata, fifo_head;
  logic              fifo_full, fifo_empty;
  logic              w_reg_hit, r_reg_hit;
  assign w_reg_hit = waddr_q < REG_LIM;
  assign r_reg_hit = addr_sel < REG_LIM;

  cbi_regfile #(.N_REGS(N_REGS)) i_regs (
    .clk_i, .rst_ni,
    .we_i   (commit & w_reg_hit),
    .be_i   (be_q),
    .waddr_i(waddr_q[IDX_W-1:0]),
    .wdata_i(wdata_q),
    .raddr_i(addr_sel[IDX_W-1:0]),
    .rdata_o(reg_rdata),
    .swap_o (swap_en)
  );

  cbi_fifo #(.DEPTH(FIFO_DEPTH)) i_fifo (
    .clk_i, .rst_ni,
    .push_i (commit && waddr_q == FIFO_ADDR),
    .din_i  (swap_en ? byte_swap(wdata_q) : wdata_q),
    .pop_i  (rd_end && raddr_q == FIFO_ADDR),
    .head_o (fifo_head),
    .full_o (fifo_full),
    .empty_o(fifo_empty)
  );

  logic [DATA_W-1:0] rdata;
  always_comb begin
    if (r_reg_hit)                  rdata = reg_rdata;
    else if (addr_sel == FIFO_ADDR) rdata = swap_en ? byte_swap(fifo_head) : fifo_head;
    else                            rdata = '0;
  end

  assign data_oe_o = rd_act;
  assign data_o    = rd_act ? rdata : '0;

  a_r1_mode_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_done |=> $stable(mode_q));
  a_r3_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ale_fall |=> $stable(ale_addr));
  a_r6_single_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> !commit);
  a_r10_empty_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_empty && rd_act && addr_sel == FIFO_ADDR) |-> data_o == '0);
  a_r5_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs_s) && cs_s |-> !data_oe_o);
endmodule

// File: tb/test_cpu_bus_if.sv
module test_cpu_bus_if;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap = 1'b0;
  logic        cs_n = 1'b1, rd_n = 1'b1, wlo_n = 1'b1, whi_n = 1'b1, ale = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic        oe;

  int vectors = 0;
  int miscompares = 0;
  bit mux = 0;
  bit done = 0;

  logic [15:0] m_regs [4];
  logic [15:0] m_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_bus_if i_cpu_bus_if (
    .clk_i(clk), .rst_ni(rst_n), .mode_strap_i(strap),
    .cs_ni(cs_n), .rd_ni(rd_n), .wr_lo_ni(wlo_n), .wr_hi_ni(whi_n),
    .ale_i(ale), .addr_i(addr), .data_i(din),
    .data_o(dout), .data_oe_o(oe)
  );

  function automatic logic [15:0] sw(input logic [15:0] d);
    return {d[7:0], d[15:8]};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // R5 reference: enable is raw (cs & rd low) delayed by two clocks
  logic h1, h2;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin h1 <= 1'b0; h2 <= 1'b0; end
    else begin h1 <= ~cs_n & ~rd_n; h2 <= h1; end
  end
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R5 oe", {15'b0, oe}, {15'b0, h2});
      if (!h2) check("R5 idle bus", dout, 16'h0000);
    end
  end

  function automatic logic [15:0] model_read(input logic [5:0] a);
    if (a < 6'd4) return m_regs[a[1:0]];
    if (a == 6'h08) return (m_q.size() == 0) ? 16'h0 : (m_regs[0][0] ? sw(m_q[0]) : m_q[0]);
    return 16'h0;
  endfunction

  task automatic model_write(input logic [5:0] a, input logic [15:0] d, input bit lo, input bit hi);
    if (a < 6'd4) begin
      if (lo) m_regs[a[1:0]][7:0]  = d[7:0];
      if (hi) m_regs[a[1:0]][15:8] = d[15:8];
    end else if (a == 6'h08 && m_q.size() < 4) begin
      m_q.push_back(m_regs[0][0] ? sw(d) : d);
    end
  endtask

  task automatic addr_phase(input logic [5:0] a);
    if (mux) begin
      addr = 6'h3F;
      din = {9'b0, a, 1'b0};
      ale = 1'b1;
      repeat (3) @(negedge clk);
      ale = 1'b0;
      repeat (4) @(negedge clk);
    end else begin
      addr = a;
      din = 16'h0;
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [15:0] d, input bit lo, input bit hi);
    @(negedge clk);
    addr_phase(a);
    din = d;
    cs_n = 1'b0; wlo_n = ~lo; whi_n = ~hi;
    repeat (4) @(negedge clk);
    wlo_n = 1'b1; whi_n = 1'b1;
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    model_write(a, d, lo, hi);
  endtask

  task automatic bus_read(input logic [5:0] a, input bit new_addr, input string tag);
    logic [15:0] exp;
    @(negedge clk);
    if (new_addr) addr_phase(a);
    din = 16'h0;
    exp = model_read(a);
    cs_n = 1'b0; rd_n = 1'b0;
    repeat (4) @(negedge clk);
    check(tag, dout, exp);
    rd_n = 1'b1;
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    if (a == 6'h08 && m_q.size() != 0) void'(m_q.pop_front());
  endtask

  task automatic do_reset(input bit s);
    @(negedge clk);
    rst_n = 1'b0; strap = s; mux = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    strap = ~s;  // R1: later strap changes must be ignored
    for (int i = 0; i < 4; i++) m_regs[i] = '0;
    m_q.delete();
  endtask

  initial begin
    // separate mode
    do_reset(1'b0);
    bus_read(6'd0, 1, "R11 ctrl after reset");
    bus_read(6'd1, 1, "R11 reg1 after reset");
    bus_read(6'h08, 1, "R11 fifo empty after reset");
    bus_write(6'd1, 16'hA55A, 1, 1);
    bus_write(6'd2, 16'h1234, 1, 1);
    bus_write(6'd3, 16'hBEEF, 1, 1);
    bus_read(6'd1, 1, "R2 R1 reg1");
    bus_read(6'd2, 1, "R2 reg2");
    bus_read(6'd3, 1, "R2 reg3");
    bus_write(6'd2, 16'h00CD, 1, 0);
    bus_read(6'd2, 1, "R4 low lane");
    bus_write(6'd2, 16'hAB11, 0, 1);
    bus_read(6'd2, 1, "R4 high lane");
    bus_write(6'd5, 16'hFFFF, 1, 1);
    bus_write(6'h20, 16'hFFFF, 1, 1);
    bus_read(6'd5, 1, "R9 unmapped read");
    bus_read(6'd1, 1, "R9 reg1 untouched");
    bus_read(6'd3, 1, "R9 reg3 untouched");
    bus_read(6'h08, 1, "R9 fifo untouched");
    bus_write(6'h08, 16'h1111, 1, 1);
    bus_write(6'h08, 16'h2222, 1, 1);
    bus_read(6'h08, 1, "R7 first out");
    bus_read(6'h08, 1, "R7 second out");
    bus_read(6'h08, 1, "R6 no duplicate push");
    bus_write(6'h08, 16'hABCD, 1, 1);
    bus_write(6'd0, 16'h0001, 1, 1);
    bus_read(6'd0, 1, "R8 ctrl set");
    bus_read(6'h08, 1, "R8 swap on pop");
    bus_write(6'h08, 16'h1234, 1, 1);
    bus_write(6'd0, 16'h0000, 1, 1);
    bus_read(6'h08, 1, "R8 swap on push");
    for (int i = 0; i < 5; i++) bus_write(6'h08, 16'h0100 + 16'(i), 1, 1);
    for (int i = 0; i < 5; i++) bus_read(6'h08, 1, "R10 full drop and empty");

    // multiplexed mode
    do_reset(1'b1);
    bus_read(6'd2, 1, "R11 mux reg2 after reset");
    bus_write(6'd1, 16'hC3C3, 1, 1);
    bus_read(6'd1, 1, "R3 R1 mux readback");
    bus_read(6'd1, 0, "R3 address held");
    bus_write(6'd3, 16'h5A00, 0, 1);
    bus_read(6'd3, 1, "R3 R4 new address");
    bus_read(6'd7, 1, "R9 mux unmapped");
    bus_write(6'h08, 16'h7788, 1, 1);
    bus_write(6'h08, 16'h99AA, 1, 1);
    bus_read(6'h08, 1, "R7 mux first");
    bus_read(6'h08, 0, "R7 mux second");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule